// File: doc/BRIEF.md
# Compressor-Tree Base Multiplier

This block is a purely combinational unsigned multiplier that forms the base cell of a larger hierarchical multiplier. Two operands of `WIDTH` bits (eight by default) give their full `2*WIDTH`-bit product in the same cycle. Every operand-bit pair is ANDed into a partial product. The lowest product bit is the single weight-one partial product and goes straight to the output. All other weights pass through a reduction tree, and one carry-propagate add at the end combines the two rows that remain.

The tree has two levels for the default width. Each level is made of row compressors, and each row compressor is a chain of four-to-two cells. Each cell has four data inputs and one carry from its lower neighbour. It produces a sum, a carry into the next weight, and a forwarded carry. The forwarded carry is chosen by a multiplexer from the cell's own data inputs and never from the incoming carry, so a change at the low end of a row cannot ripple along that row. In the cell, one XOR tree feeds both the sum and the carry multiplexer.

Top module: `baseMulCompress`

## Requirements
- R1: With one-hot operands `opA = 1<<i` and `opB = 1<<j`, `product` equals `1<<(i+j)`, so each AND-formed partial product lands at weight i+j.
- R2: `product[0]` always equals `opA[0] & opB[0]`.
- R3: The four-to-two cell's `sumOut` equals the XOR of `inA`, `inB`, `inC`, `inD` and `carryIn`.
- R4: The cell's `carryFwd` equals `inC` when `inA ^ inB` is 1 and equals `inA` otherwise. It does not depend on `carryIn`.
- R5: The cell's `carryOut` equals `inA ^ inB ^ inC` when `carryIn ^ inD` is 1 and equals `carryIn` otherwise.
- R6: For all 32 cell input combinations, `inA+inB+inC+inD+carryIn` equals `sumOut + 2*(carryOut+carryFwd)`.
- R7: `product` equals the exact unsigned product `opA*opB` for every operand pair.
- R8: A zero operand gives a zero product. Two all-ones operands give `(2^WIDTH-1)^2`, which is 16'hFE01 at the default width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opA | input | WIDTH | Unsigned multiplicand |
| opB | input | WIDTH | Unsigned multiplier |
| product | output | 2*WIDTH | Unsigned product, combinational |

## Verification
All 32 input patterns of the cell are applied. A forwarded carry that wrongly followed the incoming carry, or a swapped selection in the multiplexer, would unbalance the weighted sum and show at once. The multiplier is driven through every operand pair, then through one-hot pairs, zero operands and all-ones operands, plus seeded random pairs. A misplaced partial product, a lost top carry, or a low bit routed through the tree would corrupt particular product weights, and the all-ones case stresses the longest carry chain in the final add.

// File: rtl/mulPkg.sv
`timescale 1ns/1ps
package mulPkg;
  localparam int unsigned MUL_W = 8;
  localparam int unsigned MUL_PW = 2 * MUL_W;
endpackage

// File: rtl/cmp42Cell.sv
`timescale 1ns/1ps
module cmp42Cell (
  input  logic inA,
  input  logic inB,
  input  logic inC,
  input  logic inD,
  input  logic carryIn,
  output logic sumOut,
  output logic carryOut,
  output logic carryFwd
);
  logic abDiff;
  logic mVal;
  logic nVal;

  always_comb begin
    abDiff   = inA ^ inB;
    mVal     = abDiff ^ inC;
    nVal     = carryIn ^ inD;
    sumOut   = mVal ^ nVal;
    carryFwd = abDiff ? inC : inA;
    carryOut = nVal ? mVal : carryIn;
  end
endmodule

// File: rtl/rowCompress.sv
`timescale 1ns/1ps
module rowCompress #(
  parameter int unsigned PW = 16
) (
  input  logic [PW-1:0] rowA,
  input  logic [PW-1:0] rowB,
  input  logic [PW-1:0] rowC,
  input  logic [PW-1:0] rowD,
  output logic [PW-1:0] sumRow,
  output logic [PW-1:0] carRow
);
  logic [PW-2:0] fwd;
  logic [PW-2:0] cOut;

  for (genvar i = 0; i < PW; i++) begin : bitCol
    if (i == 0) begin : lsbCell
      cmp42Cell uCell (
        .inA(rowA[i]), .inB(rowB[i]), .inC(rowC[i]), .inD(rowD[i]),
        .carryIn(1'b0), .sumOut(sumRow[i]), .carryOut(cOut[i]), .carryFwd(fwd[i])
      );
    end else if (i < PW - 1) begin : midCell
      cmp42Cell uCell (
        .inA(rowA[i]), .inB(rowB[i]), .inC(rowC[i]), .inD(rowD[i]),
        .carryIn(fwd[i-1]), .sumOut(sumRow[i]), .carryOut(cOut[i]), .carryFwd(fwd[i])
      );
    end else begin : msbSum
      assign sumRow[i] = rowA[i] ^ rowB[i] ^ rowC[i] ^ rowD[i] ^ fwd[i-1];
    end
  end

  assign carRow = {cOut, 1'b0};
endmodule

// File: rtl/ppGen.sv
`timescale 1ns/1ps
module ppGen #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [PW-1:0]    ppRows [WIDTH],
  output logic             ppLsb
);
  always_comb begin
    for (int r = 0; r < WIDTH; r++) begin
      ppRows[r] = {{WIDTH{1'b0}}, opA & {WIDTH{opB[r]}}} << r;
    end
    ppRows[0][0] = 1'b0;
    ppLsb = opA[0] & opB[0];
  end
endmodule

// File: rtl/mulTree.sv
`timescale 1ns/1ps
module mulTree #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = 2 * WIDTH,
  localparam int unsigned LEVELS = $clog2(WIDTH) - 1
) (
  input  logic [PW-1:0] ppRows [WIDTH],
  output logic [PW-1:0] total
);
  for (genvar l = 0; l < LEVELS; l++) begin : lvlBlk
    localparam int unsigned IN_ROWS = WIDTH >> l;
    localparam int unsigned OUT_ROWS = IN_ROWS / 2;
    logic [PW-1:0] src [IN_ROWS];
    logic [PW-1:0] nxt [OUT_ROWS];

    if (l == 0) begin : fromPp
      assign src = ppRows;
    end else begin : fromPrev
      assign src = lvlBlk[l-1].nxt;
    end

    for (genvar g = 0; g < OUT_ROWS / 2; g++) begin : grp
      rowCompress #(.PW(PW)) uRow (
        .rowA(src[4*g]), .rowB(src[4*g+1]), .rowC(src[4*g+2]), .rowD(src[4*g+3]),
        .sumRow(nxt[2*g]), .carRow(nxt[2*g+1])
      );
    end
  end

  assign total = lvlBlk[LEVELS-1].nxt[0] + lvlBlk[LEVELS-1].nxt[1];
endmodule

// File: rtl/baseMulCompress.sv
`timescale 1ns/1ps
module baseMulCompress #(
  parameter int unsigned WIDTH = mulPkg::MUL_W,
  localparam int unsigned PW = 2 * WIDTH
) (
  input  logic [WIDTH-1:0] opA,
  input  logic [WIDTH-1:0] opB,
  output logic [PW-1:0]    product
);
  logic [PW-1:0] ppRows [WIDTH];
  logic          ppLsb;
  logic [PW-1:0] treeSum;

  ppGen #(.WIDTH(WIDTH)) uPp (
    .opA(opA), .opB(opB), .ppRows(ppRows), .ppLsb(ppLsb)
  );

  mulTree #(.WIDTH(WIDTH)) uTree (
    .ppRows(ppRows), .total(treeSum)
  );

  assign product = treeSum | {{(PW-1){1'b0}}, ppLsb};
endmodule

// File: rtl/baseMulCompress_chk.sv
`timescale 1ns/1ps
module baseMulCompress_chk #(
  parameter int unsigned WIDTH = 8,
  localparam int unsigned PW = 2 * WIDTH
) (
  input logic [WIDTH-1:0] opA,
  input logic [WIDTH-1:0] opB,
  input logic [PW-1:0]    product
);
  always_comb begin
    if (!$isunknown({opA, opB})) begin
      AST_PRODUCT_EXACT: assert (product == PW'(opA) * PW'(opB)); // R7
      AST_LSB_DIRECT: assert (product[0] == (opA[0] & opB[0])); // R2
      AST_ZERO_ABSORB: assert (!(opA == '0 || opB == '0) || product == '0); // R8
    end
  end
endmodule

module cmp42Cell_chk (
  input logic inA,
  input logic inB,
  input logic inC,
  input logic inD,
  input logic carryIn,
  input logic sumOut,
  input logic carryOut,
  input logic carryFwd
);
  always_comb begin
    if (!$isunknown({inA, inB, inC, inD, carryIn})) begin
      AST_CELL_BALANCE: assert ((3'(inA) + 3'(inB) + 3'(inC) + 3'(inD) + 3'(carryIn))
                                == (3'(sumOut) + 3'(2) * (3'(carryOut) + 3'(carryFwd)))); // R6
      AST_CELL_PARITY: assert (sumOut == (inA ^ inB ^ inC ^ inD ^ carryIn)); // R3
    end
  end
endmodule

bind baseMulCompress baseMulCompress_chk #(.WIDTH(WIDTH)) uChk (.*);
bind cmp42Cell cmp42Cell_chk uCellChk (.*);

// File: tb/sim_baseMulCompress.sv
`timescale 1ns/1ps
module sim_baseMulCompress;
  localparam int unsigned W = 8;
  localparam int unsigned PW = 2 * W;
  localparam time PERIOD = 10ns;

  logic clk = 1'b0;
  always #(PERIOD/2) clk = ~clk;

  logic [W-1:0]  opA = '0;
  logic [W-1:0]  opB = '0;
  logic [PW-1:0] product;

  logic cA = 0, cB = 0, cC = 0, cD = 0, cIn = 0;
  logic cS, cCar, cFwd;

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  baseMulCompress #(.WIDTH(W)) u0 (.opA(opA), .opB(opB), .product(product));
  cmp42Cell uCell (.inA(cA), .inB(cB), .inC(cC), .inD(cD), .carryIn(cIn),
                   .sumOut(cS), .carryOut(cCar), .carryFwd(cFwd));

  function automatic logic [PW-1:0] refMul(input logic [W-1:0] a, input logic [W-1:0] b);
    logic [PW-1:0] acc = '0;
    for (int k = 0; k < W; k++) if (b[k]) acc = acc + (PW'(a) << k);
    return acc;
  endfunction

  task automatic check(input string req, input logic [PW-1:0] act, input logic [PW-1:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %h expected %h (opA=%h opB=%h)", req, act, exp, opA, opB);
    end
  endtask

  task automatic applyMul(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
    @(posedge clk);
    opA = a; opB = b;
    #(PERIOD/4);
    check(req, product, refMul(a, b));
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    // R8: idle state with zero operands
    #(PERIOD/4);
    check("R8 idle zero", product, '0);

    // Cell: all 32 patterns, R3 R4 R5 R6
    for (int v = 0; v < 32; v++) begin
      logic [2:0] lhs, rhs;
      @(posedge clk);
      {cA, cB, cC, cD, cIn} = 5'(v);
      #(PERIOD/4);
      check("R3 cell sum", PW'(cS), PW'(cA ^ cB ^ cC ^ cD ^ cIn));
      check("R4 cell fwd", PW'(cFwd), PW'((cA ^ cB) ? cC : cA));
      check("R5 cell carry", PW'(cCar), PW'((cIn ^ cD) ? (cA ^ cB ^ cC) : cIn));
      lhs = 3'(cA) + 3'(cB) + 3'(cC) + 3'(cD) + 3'(cIn);
      rhs = 3'(cS) + 3'(2) * (3'(cCar) + 3'(cFwd));
      check("R6 cell balance", PW'(rhs), PW'(lhs));
    end

    // R4: forwarded carry unchanged when only carryIn toggles
    for (int v = 0; v < 16; v++) begin
      logic f0;
      @(posedge clk);
      {cA, cB, cC, cD} = 4'(v); cIn = 0;
      #(PERIOD/4);
      f0 = cFwd;
      cIn = 1;
      #(PERIOD/8);
      check("R4 fwd ignores carryIn", PW'(cFwd), PW'(f0));
    end

    // R8 corners
    applyMul('0, '1, "R8 zero A");
    applyMul('1, '0, "R8 zero B");
    applyMul('1, '1, "R8 all ones");
    check("R8 all ones literal", product, 16'hFE01);

    // R1 one-hot placement
    for (int i = 0; i < W; i++)
      for (int j = 0; j < W; j++) begin
        applyMul(W'(1) << i, W'(1) << j, "R1 one-hot");
        check("R1 weight", product, PW'(1) << (i + j));
      end

    // R2 and R7 exhaustive
    for (int a = 0; a < (1 << W); a++)
      for (int b = 0; b < (1 << W); b++) begin
        applyMul(W'(a), W'(b), "R7 exhaustive");
        if ((a & b & 1) != int'(product[0])) begin
          compared++; mismatched++;
          $display("FAIL R2 lsb: actual %b expected %b", product[0], a & b & 1);
        end else compared++;
      end

    // R7 random
    for (int n = 0; n < 2000; n++) applyMul(W'($urandom), W'($urandom), "R7 random");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule